// File: doc/BRIEF.md
# Scatter-Gather Request Packetizer

This block sits between a processing element and a scatter-gather memory fabric. It collects single load and store requests and packs them into fixed 64-byte bursts, so a burst holds only the words that were asked for. A store burst holds up to four tuples. Each tuple is a 64-bit address, its 64-bit data word and an 8-bit byte-enable mask, so a partial write marks only the bytes it changes. A load burst holds up to eight 64-bit addresses and no data. Stores are sent as tuples and no ownership read comes before them.

Requests arrive on a valid/ready interface, each tagged with a target ID and a kind. One burst carries one kind for one target. The block closes the open burst when it fills, when a request comes in for another target or of the other kind, or when `flush` is raised. A closed burst goes out as eight 64-bit beats, one per cycle, in back-to-back cycles. A side-band header is held stable for all eight beats. It carries the kind, the tuple count, the target and the byte-enable masks.

Top module: `sgp_packetizer`

## Requirements
- R1: Every burst is exactly 8 consecutive cycles with `out_valid` high, and `out_last` is high only on the eighth.
- R2: `out_kind` is 1 for a store burst and 0 for a load burst.
- R3: In a store burst, tuple i (in arrival order) puts its address on beat 2i and its data on beat 2i+1. Beats of unused tuples are zero.
- R4: In a load burst, address i (in arrival order) is on beat i. Unused beats are zero and `out_masks` is zero.
- R5: In a store burst, `out_masks[8i+7:8i]` is the byte-enable mask of tuple i. Bits of unused tuples are zero.
- R6: `out_count` is the number of requests in the burst: 1 to 4 for stores, 1 to 8 for loads.
- R7: A burst that reaches capacity (4 stores or 8 loads) starts serializing on the cycle after its last request is accepted.
- R8: A request whose target or kind differs from the open burst is accepted. It closes the open burst, which starts serializing on the next cycle, and it becomes the first entry of a new burst. Target and kind are never mixed within one burst.
- R9: `flush` high while idle with a non-empty open burst sends that burst. `flush` with nothing collected has no effect. `flush` while a burst is being serialized is ignored.
- R10: `in_ready` is low while a burst is serializing, in the cycle after a burst fills, and while `flush` is high.
- R11: After reset `out_valid` is 0, `in_ready` is 1 and nothing is collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_store | input | 1 | 1 = store, 0 = load |
| in_target | input | TGT_W | Destination target ID |
| in_addr | input | 64 | Request address |
| in_data | input | 64 | Store data (ignored for loads) |
| in_bmask | input | 8 | Store byte enables (ignored for loads) |
| flush | input | 1 | Send the partly filled burst |
| out_valid | output | 1 | Beat valid |
| out_last | output | 1 | Eighth beat of the burst |
| out_beat | output | 64 | Payload beat |
| out_kind | output | 1 | Burst kind, 1 = store |
| out_count | output | 4 | Tuple count |
| out_target | output | TGT_W | Burst target ID |
| out_masks | output | 32 | Byte-enable masks, 8 bits per store tuple |

## Verification
A wrong slot index or a missed clear in the collector shows up on `out_beat` or `out_masks` as a misplaced or stale word. This happens on the first burst after the fault, at the exact beat the bench predicts. A wrong fill count or a wrong mismatch decision changes `in_ready` or the `out_valid` start cycle. The bench compares both on every cycle, so a control fault is reported within one cycle of the wrong decision. Stale data left over from a longer earlier burst is caught by following full bursts with short, flushed ones.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  typedef enum logic {K_LOAD = 1'b0, K_STORE = 1'b1} kind_e;

  function automatic int unsigned burst_cap(input logic is_store,
                                            input int unsigned st_cap,
                                            input int unsigned ld_cap);
    return is_store ? st_cap : ld_cap;
  endfunction
endpackage

// File: rtl/sgp_accum.sv
module sgp_accum #(
  parameter int unsigned BEATS  = 8,
  parameter int unsigned W      = 64,
  parameter int unsigned TGT_W  = 4,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned ST_CAP = BEATS / 2,
  parameter int unsigned CNT_W  = $clog2(BEATS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       start,
  input  logic                       push,
  input  logic                       req_store,
  input  logic [TGT_W-1:0]           req_tgt,
  input  logic [W-1:0]               req_addr,
  input  logic [W-1:0]               req_data,
  input  logic [MASK_W-1:0]          req_mask,
  output logic [BEATS*W-1:0]         words_o,
  output logic [ST_CAP*MASK_W-1:0]   masks_o,
  output logic [CNT_W-1:0]           count_o,
  output logic                       store_o,
  output logic [TGT_W-1:0]           tgt_o
);
  import sgp_pkg::*;
  localparam int unsigned IW = $clog2(BEATS);
  localparam int unsigned MI = (ST_CAP > 1) ? $clog2(ST_CAP) : 1;

  logic [W-1:0]      words_q [BEATS];
  logic [MASK_W-1:0] masks_q [ST_CAP];
  logic [CNT_W-1:0]  count_q;
  kind_e             kind_q;
  logic [TGT_W-1:0]  tgt_q;

  logic [CNT_W-1:0]  slot;
  logic [IW-1:0]     ia, id;
  logic [MI-1:0]     mi;

  always_comb begin
    slot = start ? '0 : count_q;
    ia   = req_store ? IW'({slot, 1'b0}) : IW'(slot);
    id   = IW'({slot, 1'b1});
    mi   = MI'(slot);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
      kind_q  <= K_LOAD;
      tgt_q   <= '0;
      for (int i = 0; i < int'(BEATS); i++) words_q[i] <= '0;
      for (int i = 0; i < int'(ST_CAP); i++) masks_q[i] <= '0;
    end else if (start || push) begin
      if (start) begin
        for (int i = 0; i < int'(BEATS); i++) words_q[i] <= '0;
        for (int i = 0; i < int'(ST_CAP); i++) masks_q[i] <= '0;
        kind_q  <= req_store ? K_STORE : K_LOAD;
        tgt_q   <= req_tgt;
        count_q <= CNT_W'(1);
      end else begin
        count_q <= count_q + CNT_W'(1);
      end
      words_q[ia] <= req_addr;
      if (req_store) begin
        words_q[id] <= req_data;
        masks_q[mi] <= req_mask;
      end
    end
  end

  generate
    for (genvar g = 0; g < int'(BEATS); g++) begin : g_words
      assign words_o[g*W +: W] = words_q[g];
    end
    for (genvar g = 0; g < int'(ST_CAP); g++) begin : g_masks
      assign masks_o[g*MASK_W +: MASK_W] = masks_q[g];
    end
  endgenerate

  assign count_o = count_q;
  assign store_o = (kind_q == K_STORE);
  assign tgt_o   = tgt_q;

  // R7: the collector never holds more than one burst's worth of requests
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    32'(count_q) <= burst_cap(store_o, ST_CAP, BEATS));
endmodule

// File: rtl/sgp_serial.sv
module sgp_serial #(
  parameter int unsigned BEATS = 8,
  parameter int unsigned W     = 64,
  parameter int unsigned TGT_W = 4,
  parameter int unsigned MW    = 32,
  parameter int unsigned CNT_W = $clog2(BEATS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [BEATS*W-1:0]   words_i,
  input  logic [MW-1:0]        masks_i,
  input  logic [CNT_W-1:0]     count_i,
  input  logic                 store_i,
  input  logic [TGT_W-1:0]     tgt_i,
  output logic                 busy_o,
  output logic                 last_o,
  output logic [W-1:0]         beat_o,
  output logic                 kind_o,
  output logic [CNT_W-1:0]     count_o,
  output logic [TGT_W-1:0]     tgt_o,
  output logic [MW-1:0]        masks_o
);
  localparam int unsigned IW = $clog2(BEATS);

  logic [W-1:0]     sbuf_q [BEATS];
  logic [IW-1:0]    beat_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      beat_q  <= '0;
      kind_o  <= 1'b0;
      count_o <= '0;
      tgt_o   <= '0;
      masks_o <= '0;
    end else if (load && !busy_q) begin
      busy_q  <= 1'b1;
      beat_q  <= '0;
      kind_o  <= store_i;
      count_o <= count_i;
      tgt_o   <= tgt_i;
      masks_o <= masks_i;
      for (int i = 0; i < int'(BEATS); i++) sbuf_q[i] <= words_i[i*W +: W];
    end else if (busy_q) begin
      beat_q <= beat_q + IW'(1);
      if (beat_q == IW'(BEATS - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (beat_q == IW'(BEATS - 1));
  assign beat_o = sbuf_q[beat_q];

  // R1: beats of one burst follow each other without a gap
  a_r1_beats_contiguous: assert property (@(posedge clk) disable iff (rst)
    busy_q && (beat_q != IW'(BEATS - 1)) |=> busy_q && (beat_q == $past(beat_q) + IW'(1)));
endmodule

// File: rtl/sgp_packetizer.sv
module sgp_packetizer #(
  parameter int unsigned BEATS  = 8,
  parameter int unsigned W      = 64,
  parameter int unsigned TGT_W  = 4,
  parameter int unsigned MASK_W = W / 8,
  parameter int unsigned ST_CAP = BEATS / 2,
  parameter int unsigned CNT_W  = $clog2(BEATS + 1),
  parameter int unsigned MW     = ST_CAP * MASK_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_store,
  input  logic [TGT_W-1:0]   in_target,
  input  logic [W-1:0]       in_addr,
  input  logic [W-1:0]       in_data,
  input  logic [MASK_W-1:0]  in_bmask,
  input  logic               flush,
  output logic               out_valid,
  output logic               out_last,
  output logic [W-1:0]       out_beat,
  output logic               out_kind,
  output logic [CNT_W-1:0]   out_count,
  output logic [TGT_W-1:0]   out_target,
  output logic [MW-1:0]      out_masks
);
  import sgp_pkg::*;

  logic [BEATS*W-1:0] acc_words;
  logic [MW-1:0]      acc_masks;
  logic [CNT_W-1:0]   acc_count;
  logic               acc_store;
  logic [TGT_W-1:0]   acc_tgt;
  logic               busy, empty, full, accept, mismatch;
  logic               launch, acc_start, acc_push, acc_clr;

  always_comb begin
    empty     = (acc_count == '0);
    full      = !empty && (32'(acc_count) == burst_cap(acc_store, ST_CAP, BEATS));
    in_ready  = !busy && !full && !flush;
    accept    = in_valid && in_ready;
    mismatch  = !empty && ((in_store != acc_store) || (in_target != acc_tgt));
    acc_clr   = !busy && (full || (flush && !empty));
    acc_start = accept && (empty || mismatch);
    acc_push  = accept && !empty && !mismatch;
    launch    = acc_clr || (accept && mismatch);
  end

  sgp_accum #(.BEATS(BEATS), .W(W), .TGT_W(TGT_W), .MASK_W(MASK_W),
              .ST_CAP(ST_CAP), .CNT_W(CNT_W)) u_acc (
    .clk(clk), .rst(rst), .clr(acc_clr), .start(acc_start), .push(acc_push),
    .req_store(in_store), .req_tgt(in_target), .req_addr(in_addr),
    .req_data(in_data), .req_mask(in_bmask),
    .words_o(acc_words), .masks_o(acc_masks), .count_o(acc_count),
    .store_o(acc_store), .tgt_o(acc_tgt));

  sgp_serial #(.BEATS(BEATS), .W(W), .TGT_W(TGT_W), .MW(MW), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst(rst), .load(launch), .words_i(acc_words), .masks_i(acc_masks),
    .count_i(acc_count), .store_i(acc_store), .tgt_i(acc_tgt),
    .busy_o(busy), .last_o(out_last), .beat_o(out_beat), .kind_o(out_kind),
    .count_o(out_count), .tgt_o(out_target), .masks_o(out_masks));

  assign out_valid = busy;

  // R10: no request is taken while a burst is on the wire
  a_r10_ready_low_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);
  // R6: the count in the header is within the kind's capacity
  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_count != '0) && (32'(out_count) <= burst_cap(out_kind, ST_CAP, BEATS)));
  // R4: load bursts carry no byte enables
  a_r4_load_mask_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_kind |-> out_masks == '0);
  // R8: a foreign request closes the open burst, which goes out next cycle
  a_r8_mismatch_sends: assert property (@(posedge clk) disable iff (rst)
    accept && mismatch |=> out_valid && !$past(out_valid));
endmodule

// File: tb/sim_sgp_packetizer.sv
module sim_sgp_packetizer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_store = 1'b0, flush = 1'b0;
  logic [3:0]  in_target = '0;
  logic [63:0] in_addr = '0, in_data = '0;
  logic [7:0]  in_bmask = '0;
  logic        in_ready, out_valid, out_last, out_kind;
  logic [63:0] out_beat;
  logic [3:0]  out_count, out_target;
  logic [31:0] out_masks;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sgp_packetizer u0 (.*);

  // reference model
  logic [63:0] qa[$], qd[$];
  logic [7:0]  qm[$];
  bit          m_store;
  logic [3:0]  m_tgt;
  int          send_left = 0;
  logic [63:0] eb[8];
  bit          e_kind;
  int          e_cnt;
  logic [3:0]  e_tgt;
  logic [31:0] e_masks;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cap_of(bit s);
    return s ? 4 : 8;
  endfunction

  task automatic build();
    for (int i = 0; i < 8; i++) eb[i] = '0;
    e_masks = '0;
    e_kind  = m_store;
    e_cnt   = qa.size();
    e_tgt   = m_tgt;
    for (int i = 0; i < qa.size(); i++) begin
      if (m_store) begin
        eb[2*i] = qa[i];
        eb[2*i+1] = qd[i];
        e_masks[8*i +: 8] = qm[i];
      end else begin
        eb[i] = qa[i];
      end
    end
    qa.delete(); qd.delete(); qm.delete();
    send_left = 8;
  endtask

  function automatic bit m_ready();
    return (send_left == 0) && !(qa.size() != 0 && qa.size() == cap_of(m_store)) && !flush;
  endfunction

  always @(posedge clk) begin
    bit rdy;
    rdy = m_ready();
    if (rst) begin
      qa.delete(); qd.delete(); qm.delete();
      send_left = 0;
    end else if (send_left > 0) begin
      send_left--;
    end else if (qa.size() != 0 && (qa.size() == cap_of(m_store) || flush)) begin
      build();
    end else if (in_valid && rdy) begin
      if (qa.size() != 0 && (in_store != m_store || in_target != m_tgt)) build();
      if (qa.size() == 0) begin
        m_store = in_store;
        m_tgt   = in_target;
      end
      qa.push_back(in_addr);
      qd.push_back(in_data);
      qm.push_back(in_bmask);
    end
    #2;
    if (!rst && !done) begin
      chk("R10 in_ready", 64'(in_ready), 64'(m_ready()));
      chk("R1 out_valid", 64'(out_valid), 64'(send_left > 0));
      if (send_left > 0) begin
        chk("R1 out_last", 64'(out_last), 64'(send_left == 1));
        chk(e_kind ? "R3 store beat" : "R4 load beat", out_beat, eb[8 - send_left]);
        chk("R2 kind", 64'(out_kind), 64'(e_kind));
        chk("R6 count", 64'(out_count), 64'(e_cnt));
        chk("R8 target", 64'(out_target), 64'(e_tgt));
        chk("R5 masks", 64'(out_masks), 64'(e_masks));
      end
    end
  end

  task automatic send(bit s, logic [3:0] t, logic [63:0] a, logic [63:0] d, logic [7:0] m);
    @(negedge clk);
    in_valid = 1; in_store = s; in_target = t; in_addr = a; in_data = d; in_bmask = m;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_flush(int n);
    @(negedge clk); flush = 1;
    repeat (n) @(negedge clk);
    flush = 0;
  endtask

  initial begin
    int unsigned r = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset in_ready", 64'(in_ready), 64'd1);
    // R7: four stores fill a burst
    for (int i = 0; i < 4; i++) send(1, 4'd3, 64'h1000 + 64'(i*8), 64'hA0A0_0000 + 64'(i), 8'h1 << i);
    idle(12);
    // R7: eight loads fill a burst
    for (int i = 0; i < 8; i++) send(0, 4'd5, 64'h2000 + 64'(i*64), '0, 8'hFF);
    idle(12);
    // R8: target change then kind change, R9 flush closes the last
    send(1, 4'd1, 64'h3000, 64'h11, 8'h0F);
    send(1, 4'd1, 64'h3008, 64'h22, 8'hF0);
    send(1, 4'd2, 64'h3010, 64'h33, 8'h3C);
    send(0, 4'd2, 64'h3018, '0, 8'h00);
    idle(10);
    pulse_flush(1);
    idle(12);
    // R9: flush with nothing collected has no effect
    pulse_flush(3);
    idle(4);
    // R9: flush held through a send is ignored until the send ends
    send(0, 4'd7, 64'h4000, '0, 8'h00);
    send(0, 4'd6, 64'h4008, '0, 8'h00);
    pulse_flush(14);
    idle(12);
    // mixed stream
    for (int n = 0; n < 200; n++) begin
      r = r * 32'd1103515245 + 32'd12345;
      send(r[20], {2'b00, r[22:21]}, {32'd0, r}, {r, ~r}, r[31:24]);
      if (r[27:25] == 3'd0) pulse_flush(1);
      if (r[29:28] == 2'd0) idle(int'(r[2:0]));
    end
    pulse_flush(1);
    idle(12);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule